// File: doc/BRIEF.md
# Converter Core Reset Sequencer

This block sequences the reset of an audio converter's digital core. A control register supplies a run-request bit, and a strobe that pulses once per audio frame sets the pace. The block works out when the internal core reset asserts and when it releases. It also decides how long the ADC side stays in its start-up cycle after release, when ADC data and the serial data line must be held quiet, and when the two zero-detect flags are shown. Every delay is counted in frame ticks on the system clock. With no strobe, the sequence holds where it is. This lets the frame clock stop while the core is held in reset.

When the request drops to 0, the internal reset asserts after a frame-counted delay. When the request returns to 1, the reset releases after a shorter delay. A fixed-length ADC start-up cycle then follows, and only after it ends is ADC data passed through. A combined busy flag covers the whole span from the request dropping to the end of the start-up cycle, so a host can poll it. If the request drops again during the release delay or the start-up cycle, the sequence returns at once to the reset path. The block owns no configuration storage, so configuration registers elsewhere keep their contents through the reset.

Top module: `codec_rst_seq`

## Requirements
- R1: While the system reset `rst_n` is low, and in the first cycle after it, `core_rst_n` is 0, `adc_pd`, `adc_zero`, `sdo_low` and `seq_busy` are 1, `adc_init_busy` is 0, and both `zdet` bits are 1.
- R2: In normal run, when `run_req` is sampled 0, `core_rst_n` falls on the clock edge that samples the 5th `frame_tick` after that. Ticks 1 to 4 only count.
- R3: If `run_req` is sampled 1 again before the 5th tick of the entry delay, entry is cancelled. `core_rst_n` never falls and `seq_busy` returns to 0 on that edge.
- R4: In reset, when `run_req` is sampled 1, `core_rst_n` rises on the edge that samples the 2nd `frame_tick` after that.
- R5: `adc_init_busy` rises together with `core_rst_n`. With `run_req` held at 1, it falls on the edge that samples the 516th `frame_tick` of the start-up cycle.
- R6: `adc_pd` and `sdo_low` are 1 exactly while `core_rst_n` is 0. `adc_zero` is 1 while `adc_pd` or `adc_init_busy` is 1.
- R7: Both `zdet` bits are 1 on the edge after any cycle in which `run_req` is 0. With `run_req` held at 1, they fall on the edge that samples the 7th `frame_tick` after `run_req` was last 0.
- R8: If `run_req` is sampled 0 during the release delay, the block returns to reset without releasing. If it is sampled 0 during the start-up cycle, `adc_init_busy` drops on that edge and the 5-tick entry delay restarts from zero.
- R9: Without a `frame_tick`, no count advances. `core_rst_n`, `adc_init_busy` and `zdet` change only on an edge that samples a tick, apart from the request-driven changes in R3, R7 and R8.
- R10: `seq_busy` is 1 from the edge after `run_req` is sampled 0 until the start-up cycle completes, and 0 only in normal run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| run_req | input | 1 | Register bit: 1 = run, 0 = request core reset |
| frame_tick | input | 1 | One-cycle pulse per audio frame |
| core_rst_n | output | 1 | Internal delayed core reset, active low |
| adc_pd | output | 1 | ADC digital side powered down |
| adc_init_busy | output | 1 | ADC start-up cycle in progress |
| adc_zero | output | 1 | Force ADC output data to zero |
| sdo_low | output | 1 | Hold serial data output low |
| zdet | output | NUM_ZD | Zero-detect flags |
| seq_busy | output | 1 | Sequence busy, not in normal run |

## Verification
The sequence is driven with the frame strobe at several spacings: every cycle, every 2, 3, 4 and 5 cycles, and stopped. This separates counting ticks from counting clocks, and shows that a stopped strobe freezes the counts. Request drops are placed in normal run, inside the entry window, inside the release delay, and deep inside the start-up cycle. These placements tell a cancelled entry apart from a real reset, and a restarted entry delay from one that resumed an old count. Long held stretches with a steady request show that the zero-detect release and the 516-tick start-up end on the exact tick.

// File: rtl/codec_rst_seq.sv
module codec_rst_seq #(
  parameter int ENTER_WAIT = 4,
  parameter int EXIT_WAIT  = 1,
  parameter int INIT_LEN   = 516,
  parameter int ZD_WAIT    = 6,
  parameter int NUM_ZD     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic              frame_tick,
  output logic              core_rst_n,
  output logic              adc_pd,
  output logic              adc_init_busy,
  output logic              adc_zero,
  output logic              sdo_low,
  output logic [NUM_ZD-1:0] zdet,
  output logic              seq_busy
);
  localparam int CW = $clog2(INIT_LEN + 1);
  localparam int ZW = $clog2(ZD_WAIT + 2);

  typedef enum logic [2:0] {S_RUN, S_ENTER, S_HELD, S_EXIT, S_INIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          zd;
  logic [ZW-1:0] zcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_HELD;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN:
          if (!run_req) begin
            st  <= S_ENTER;
            cnt <= '0;
          end
        S_ENTER:
          if (run_req) st <= S_RUN;
          else if (frame_tick) begin
            if (cnt == CW'(ENTER_WAIT)) st <= S_HELD;
            else cnt <= cnt + 1'b1;
          end
        S_HELD:
          if (run_req) begin
            st  <= S_EXIT;
            cnt <= '0;
          end
        S_EXIT:
          if (!run_req) st <= S_HELD;
          else if (frame_tick) begin
            if (cnt == CW'(EXIT_WAIT)) begin
              st  <= S_INIT;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
        S_INIT:
          if (!run_req) begin
            st  <= S_ENTER;
            cnt <= '0;
          end else if (frame_tick) begin
            if (cnt == CW'(INIT_LEN - 1)) st <= S_RUN;
            else cnt <= cnt + 1'b1;
          end
        default: st <= S_HELD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zd   <= 1'b1;
      zcnt <= '0;
    end else if (!run_req) begin
      zd   <= 1'b1;
      zcnt <= '0;
    end else if (zd && frame_tick) begin
      if (zcnt == ZW'(ZD_WAIT)) zd <= 1'b0;
      else zcnt <= zcnt + 1'b1;
    end
  end

  assign core_rst_n    = !(st == S_HELD || st == S_EXIT);
  assign adc_pd        = !core_rst_n;
  assign sdo_low       = !core_rst_n;
  assign adc_init_busy = (st == S_INIT);
  assign adc_zero      = adc_pd || adc_init_busy;
  assign seq_busy      = (st != S_RUN);
  assign zdet          = {NUM_ZD{zd}};
endmodule

module codec_rst_seq_chk #(
  parameter int INIT_LEN = 516,
  parameter int NUM_ZD   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_req,
  input logic              frame_tick,
  input logic              core_rst_n,
  input logic              adc_pd,
  input logic              adc_init_busy,
  input logic              adc_zero,
  input logic              sdo_low,
  input logic [NUM_ZD-1:0] zdet,
  input logic              seq_busy
);
  logic [31:0] init_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_ticks <= '0;
    else if (!adc_init_busy) init_ticks <= '0;
    else if (frame_tick) init_ticks <= init_ticks + 1;
  end

  AST_RST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $fell(core_rst_n) |-> $past(frame_tick) && !$past(run_req)); // R2
  AST_RST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(core_rst_n) |-> $past(frame_tick) && $past(run_req)); // R4
  AST_INIT_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_init_busy) && $past(run_req) |-> init_ticks == INIT_LEN); // R5
  AST_INIT_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) adc_init_busy |-> core_rst_n && adc_zero && !adc_pd); // R6
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n) !core_rst_n |-> sdo_low && adc_zero && adc_pd); // R6
  AST_ZD_ON_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n) !run_req |=> &zdet); // R7
  AST_ZD_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $fell(zdet[0]) |-> $past(frame_tick) && $past(run_req)); // R9
  AST_BUSY_ON_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n) !run_req |=> seq_busy); // R10
  AST_BUSY_COVERS_RESET: assert property (@(posedge clk) disable iff (!rst_n) (!core_rst_n || adc_init_busy) |-> seq_busy); // R10
endmodule

bind codec_rst_seq codec_rst_seq_chk #(.INIT_LEN(INIT_LEN), .NUM_ZD(NUM_ZD)) u_chk (.*);

// File: tb/sim_codec_rst_seq.sv
module sim_codec_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NZD = 2;

  logic clk = 0, rst_n = 0, run_req = 0, frame_tick = 0;
  logic core_rst_n, adc_pd, adc_init_busy, adc_zero, sdo_low, seq_busy;
  logic [NZD-1:0] zdet;

  int checks = 0, failures = 0, gcyc = 0;
  bit done = 0;

  codec_rst_seq u0 (.clk, .rst_n, .run_req, .frame_tick, .core_rst_n, .adc_pd,
                    .adc_init_busy, .adc_zero, .sdo_low, .zdet, .seq_busy);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: 0 run, 1 entering, 2 held, 3 releasing, 4 start-up
  int mode = 2, left = 0, zleft = 0;
  bit zd = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 2; zd = 1; zleft = 7;
    end else begin
      case (mode)
        0: if (!run_req) begin mode = 1; left = 5; end
        1: if (run_req) mode = 0;
           else if (frame_tick) begin left--; if (left == 0) mode = 2; end
        2: if (run_req) begin mode = 3; left = 2; end
        3: if (!run_req) mode = 2;
           else if (frame_tick) begin left--; if (left == 0) begin mode = 4; left = 516; end end
        default: if (!run_req) begin mode = 1; left = 5; end
           else if (frame_tick) begin left--; if (left == 0) mode = 0; end
      endcase
      if (!run_req) begin zd = 1; zleft = 7; end
      else if (zd && frame_tick) begin zleft--; if (zleft == 0) zd = 0; end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, gcyc, act, exp);
    end
  endtask

  task automatic compare_all();
    bit in_rst = (mode == 2 || mode == 3);
    chk(core_rst_n, !in_rst, "R2/R4/R8 core_rst_n");
    chk(adc_pd, in_rst, "R6 adc_pd");
    chk(sdo_low, in_rst, "R6 sdo_low");
    chk(adc_init_busy, mode == 4, "R5 adc_init_busy");
    chk(adc_zero, in_rst || mode == 4, "R6 adc_zero");
    chk(seq_busy, mode != 0, "R10 seq_busy");
    for (int i = 0; i < NZD; i++) chk(zdet[i], zd, "R7 zdet");
  endtask

  // drive req for n cycles with a tick every per cycles (per=0: strobe stopped)
  task automatic run(input bit req, input int per, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
      run_req = req;
      frame_tick = (per != 0) && (gcyc % per == 0);
      gcyc++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(core_rst_n, 1'b0, "R1 core_rst_n");
    chk(adc_init_busy, 1'b0, "R1 adc_init_busy");
    chk(zdet[0], 1'b1, "R1 zdet");
    chk(seq_busy, 1'b1, "R1 seq_busy");
    // R4 R5 release and full start-up, tick every 3
    run(1, 3, 1600);
    chk(seq_busy, 1'b0, "R5 start-up complete");
    // R2 entry, tick every 2
    run(0, 2, 20);
    // R8 abort during release delay, R9 stopped strobe in reset
    run(1, 5, 4);
    run(0, 1, 3);
    run(0, 0, 50);
    run(1, 0, 30);
    chk(core_rst_n, 1'b0, "R9 no release without ticks");
    run(1, 4, 2200);
    // R3 cancelled entry
    run(0, 5, 12);
    run(1, 5, 40);
    chk(core_rst_n, 1'b1, "R3 entry cancelled");
    // R8 abort during start-up, then restart of entry delay
    run(0, 1, 10);
    run(1, 1, 200);
    run(0, 1, 3);
    run(1, 1, 2);
    run(0, 1, 12);
    // R9 entry paused by stopped strobe
    run(1, 2, 1100);
    run(0, 0, 40);
    run(0, 1, 8);
    run(1, 1, 600);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule